// File: doc/BRIEF.md
# Eight-Bit CPU Effective Address Generator

This block works out the 16-bit address that an instruction of a small 8-bit processor refers to. A sequencer pulses `start` with the addressing-mode code, the address of the instruction, the one or two operand bytes that follow the opcode, and the two index registers. The block returns the effective address, or for a branch the branch target, with a one-cycle `done` pulse. It also reports the length of the instruction so that the program counter can be advanced. It also raises a page-crossing flag when indexing through a pointer carries into the high byte.

Modes that go through a pointer read the two pointer bytes, low byte first, over a request/valid read port. This port is the block's only memory traffic. Pointers held in page 0 wrap inside page 0. The indirect-jump pointer keeps its high byte fixed, so a pointer at offset 0xFF of a page takes its upper byte from offset 0x00 of that same page. Modes that need no pointer finish in the cycle after `start`.

Top module: `ea_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `done` and `memReq` are 0.
- R2: Mode codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 absolute, 5 relative, 6 pre-indexed indirect (X), 7 post-indexed indirect (Y), 8 indirect jump, and any other code behaves as implied. `instLen` is 1 for implied and accumulator, 3 for absolute and indirect jump, and 2 for all other modes.
- R3: Immediate gives pc+1. Zero page gives {0x00, opLo}. Absolute gives {opHi, opLo}. Each of these, and relative, raises `done` in the cycle after `start` is sampled, with no memory request.
- R4: Relative gives pc + 2 + the sign-extended opLo, modulo 2^16.
- R5: Mode 6 reads the pointer low byte at {0x00, (opLo+X) mod 256} and the high byte at {0x00, (opLo+X+1) mod 256}. The result is {high, low}.
- R6: Mode 7 reads the pointer at {0x00, opLo} and {0x00, (opLo+1) mod 256}. The result is the 16-bit pointer plus Y. `pageCross` is 1 exactly when pointer low byte + Y exceeds 0xFF, and it is 0 in every other mode.
- R7: Mode 8 reads the low byte at {opHi, opLo} and the high byte at {opHi, (opLo+1) mod 256}, so the high byte always comes from the same page. The result is {high, low}.
- R8: Implied, accumulator and undefined codes give `hasAddr`=0 and `effAddr`=0 and make no memory request. All other modes give `hasAddr`=1.
- R9: Pointer bytes are requested low byte first. `memReq` stays high with `memAddr` unchanged until `memValid` is seen, and `memValid` may arrive in the same cycle the request first appears.
- R10: `done` is high for exactly one cycle. `effAddr`, `hasAddr`, `pageCross` and `instLen` keep their values after `done` until the next accepted `start`.
- R11: A `start` pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (accepted only when idle) |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the instruction's opcode |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| idxX | input | 8 | X index register |
| idxY | input | 8 | Y index register |
| memValid | input | 1 | Read data valid for the pending request |
| memData | input | 8 | Read data byte |
| memReq | output | 1 | Pointer-byte read request |
| memAddr | output | 16 | Pointer-byte read address |
| done | output | 1 | One-cycle completion strobe |
| effAddr | output | 16 | Effective address or branch target |
| hasAddr | output | 1 | Mode produces a memory address |
| pageCross | output | 1 | Post-indexing carried into the high byte |
| instLen | output | 2 | Instruction length in bytes |

## Verification
The bench provokes two collisions in the same cycle. In the first, the read responder answers with zero wait, so `memValid` lands in the very cycle a request first rises. The transition from the low-byte fetch to the high-byte fetch then happens on back-to-back edges. The bench judges this by the two logged request addresses and by the final address. In the second, a fresh `start` with different operands is driven in the cycle after acceptance, while the pointer fetch is pending. The bench passes only if the returned address, length and request log still match the first operation.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int MW = 4;
  localparam int LW = 2;

  typedef enum logic [MW-1:0] {
    MD_IMPL    = 4'd0,
    MD_ACC     = 4'd1,
    MD_IMM     = 4'd2,
    MD_ZPG     = 4'd3,
    MD_ABS     = 4'd4,
    MD_REL     = 4'd5,
    MD_IDX_IND = 4'd6,
    MD_IND_IDX = 4'd7,
    MD_JIND    = 4'd8
  } mode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capIn;    // latch the request operands
    logic capLo;    // latch pointer low byte
    logic capHi;    // latch pointer high byte
    logic fetchHi;  // address the high pointer byte
  } strobe_t;
endpackage

// File: rtl/ea_control.sv
module ea_control
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] modeIn,
  input  logic          memValid,
  output strobe_t       stb,
  output logic          memReq,
  output logic          done
);
  typedef enum logic [1:0] {ST_IDLE, ST_FLO, ST_FHI, ST_FIN} state_e;
  state_e state;
  logic needPtr;

  assign needPtr = (modeIn == MD_IDX_IND) || (modeIn == MD_IND_IDX) ||
                   (modeIn == MD_JIND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= needPtr ? ST_FLO : ST_FIN;
        ST_FLO:  if (memValid) state <= ST_FHI;
        ST_FHI:  if (memValid) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb    = '0;
    memReq = 1'b0;
    done   = 1'b0;
    case (state)
      ST_IDLE: stb.capIn = start;
      ST_FLO: begin
        memReq    = 1'b1;
        stb.capLo = memValid;
      end
      ST_FHI: begin
        memReq      = 1'b1;
        stb.fetchHi = 1'b1;
        stb.capHi   = memValid;
      end
      default: done = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [MW-1:0] modeIn,
  input  logic [AW-1:0] pcIn,
  input  logic [DW-1:0] opLoIn,
  input  logic [DW-1:0] opHiIn,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] yIn,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] effAddr,
  output logic          hasAddr,
  output logic          pageCross,
  output logic [LW-1:0] instLen
);
  logic [MW-1:0] modeQ;
  logic [AW-1:0] pcQ;
  logic [DW-1:0] loQ, hiQ, xQ, yQ, ptrLo, ptrHi;
  logic [DW-1:0] zpSel, zpNext, loNext;
  logic [AW-1:0] loAddr, hiAddr, ptrWord, relDisp;
  logic [DW:0]   lowSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0; pcQ <= '0; loQ <= '0; hiQ <= '0;
      xQ <= '0; yQ <= '0; ptrLo <= '0; ptrHi <= '0;
    end else begin
      if (stb.capIn) begin
        modeQ <= modeIn; pcQ <= pcIn; loQ <= opLoIn;
        hiQ <= opHiIn; xQ <= xIn; yQ <= yIn;
      end
      if (stb.capLo) ptrLo <= memData;
      if (stb.capHi) ptrHi <= memData;
    end
  end

  // pointer byte addresses: page-0 pointers wrap in page 0,
  // jump pointer keeps its page for the high byte
  assign zpSel  = (modeQ == MD_IDX_IND) ? DW'(loQ + xQ) : loQ;
  assign zpNext = DW'(zpSel + 1'b1);
  assign loNext = DW'(loQ + 1'b1);

  always_comb begin
    if (modeQ == MD_JIND) begin
      loAddr = {hiQ, loQ};
      hiAddr = {hiQ, loNext};
    end else begin
      loAddr = {{DW{1'b0}}, zpSel};
      hiAddr = {{DW{1'b0}}, zpNext};
    end
  end

  assign memAddr = stb.fetchHi ? hiAddr : loAddr;
  assign ptrWord = {ptrHi, ptrLo};
  assign lowSum  = {1'b0, ptrLo} + {1'b0, yQ};
  assign relDisp = {{DW{loQ[DW-1]}}, loQ};

  always_comb begin
    effAddr   = '0;
    hasAddr   = 1'b1;
    pageCross = 1'b0;
    instLen   = LW'(2);
    case (modeQ)
      MD_IMM:     effAddr = AW'(pcQ + 1'b1);
      MD_ZPG:     effAddr = {{DW{1'b0}}, loQ};
      MD_ABS: begin
        effAddr = {hiQ, loQ};
        instLen = LW'(3);
      end
      MD_REL:     effAddr = AW'(pcQ + AW'(2) + relDisp);
      MD_IDX_IND: effAddr = ptrWord;
      MD_IND_IDX: begin
        effAddr   = AW'(ptrWord + {{DW{1'b0}}, yQ});
        pageCross = lowSum[DW];
      end
      MD_JIND: begin
        effAddr = ptrWord;
        instLen = LW'(3);
      end
      default: begin
        hasAddr = 1'b0;
        instLen = LW'(1);
      end
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] opLo,
  input  logic [DW-1:0] opHi,
  input  logic [DW-1:0] idxX,
  input  logic [DW-1:0] idxY,
  input  logic          memValid,
  input  logic [DW-1:0] memData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic          done,
  output logic [AW-1:0] effAddr,
  output logic          hasAddr,
  output logic          pageCross,
  output logic [LW-1:0] instLen
);
  strobe_t stb;

  ea_control ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(mode),
    .memValid(memValid), .stb(stb), .memReq(memReq), .done(done)
  );

  ea_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .modeIn(mode), .pcIn(pc),
    .opLoIn(opLo), .opHiIn(opHi), .xIn(idxX), .yIn(idxY),
    .memData(memData), .memAddr(memAddr), .effAddr(effAddr),
    .hasAddr(hasAddr), .pageCross(pageCross), .instLen(instLen)
  );
endmodule

// File: rtl/ea_unit_checker.sv
module ea_unit_checker
  import ea_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memValid,
  input logic [AW-1:0] memAddr,
  input logic          done,
  input logic          hasAddr,
  input logic          pageCross,
  input logic [LW-1:0] instLen
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !done && !memReq);
  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));
  a_r9_no_req_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
  // R5 R6
  a_r5_r6_page_zero: assert property (@(posedge clk) disable iff (!rstN)
    memReq && instLen == LW'(2) |-> memAddr[AW-1:DW] == '0);
  // R7
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rstN)
    memReq && $past(memReq && memValid) && instLen == LW'(3)
      |-> memAddr[AW-1:DW] == $past(memAddr[AW-1:DW]));
  // R8
  a_r8_no_addr_short: assert property (@(posedge clk) disable iff (!rstN)
    done && !hasAddr |-> instLen == LW'(1));
  // R6
  a_r6_cross_two_bytes: assert property (@(posedge clk) disable iff (!rstN)
    done && pageCross |-> instLen == LW'(2) && hasAddr);
endmodule

bind ea_unit ea_unit_checker chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memValid(memValid),
  .memAddr(memAddr), .done(done), .hasAddr(hasAddr),
  .pageCross(pageCross), .instLen(instLen)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {mode4, wait4, pc16, opLo8, opHi8, x8, y8}
  localparam logic [55:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 16'h1000, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1, 4'd0, 16'h1001, 8'h55, 8'h66, 8'h00, 8'h00},
    {4'd2, 4'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd3, 4'd0, 16'h2000, 8'h80, 8'h44, 8'h00, 8'h00},
    {4'd4, 4'd0, 16'h2000, 8'h34, 8'h12, 8'h00, 8'h00},
    {4'd5, 4'd0, 16'h2000, 8'h10, 8'h00, 8'h00, 8'h00},
    {4'd5, 4'd0, 16'h2000, 8'hF0, 8'h00, 8'h00, 8'h00},
    {4'd6, 4'd0, 16'h3000, 8'h20, 8'h00, 8'h05, 8'h00},
    {4'd6, 4'd2, 16'h3000, 8'hFE, 8'h00, 8'h03, 8'h00},
    {4'd7, 4'd1, 16'h3000, 8'h40, 8'h00, 8'h00, 8'h10},
    {4'd7, 4'd0, 16'h3000, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {4'd8, 4'd1, 16'h4000, 8'h30, 8'h12, 8'h00, 8'h00},
    {4'd8, 4'd0, 16'h4000, 8'hFF, 8'h12, 8'h00, 8'h00},
    {4'd15, 4'd0, 16'h5000, 8'h12, 8'h34, 8'h56, 8'h78}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, memValid = 1'b0;
  logic [3:0] mode = '0;
  logic [15:0] pc = '0;
  logic [7:0] opLo = '0, opHi = '0, idxX = '0, idxY = '0, memData = '0;
  logic memReq, done, hasAddr, pageCross;
  logic [15:0] memAddr, effAddr;
  logic [1:0] instLen;

  int nChk = 0, nErr = 0, waitCycles = 0, reqN = 0, cnt = 0, cycles = 0;
  logic [15:0] reqLog [2];
  logic [15:0] prevAddr = '0;
  bit addrMoved = 0, seen = 0, doneAgain = 0;
  logic [15:0] gotEa;
  logic gotHas, gotCross;
  logic [1:0] gotLen;

  ea_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pc(pc),
    .opLo(opLo), .opHi(opHi), .idxX(idxX), .idxY(idxY),
    .memValid(memValid), .memData(memData), .memReq(memReq),
    .memAddr(memAddr), .done(done), .effAddr(effAddr),
    .hasAddr(hasAddr), .pageCross(pageCross), .instLen(instLen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  // expected {hasAddr, pageCross, instLen, effAddr} from the requirements
  function automatic logic [19:0] model(input logic [3:0] m, input logic [15:0] p,
      input logic [7:0] l, input logic [7:0] h, input logic [7:0] x, input logic [7:0] y);
    logic [7:0] z, z1;
    logic [15:0] ptr;
    logic [8:0] s;
    case (m)
      4'd2: return {1'b1, 1'b0, 2'd2, 16'(p + 16'd1)};
      4'd3: return {1'b1, 1'b0, 2'd2, 8'h00, l};
      4'd4: return {1'b1, 1'b0, 2'd3, h, l};
      4'd5: return {1'b1, 1'b0, 2'd2, 16'(p + 16'd2 + {{8{l[7]}}, l})};
      4'd6: begin
        z = 8'(l + x); z1 = 8'(z + 8'd1);
        return {1'b1, 1'b0, 2'd2, memByte({8'h00, z1}), memByte({8'h00, z})};
      end
      4'd7: begin
        z1 = 8'(l + 8'd1);
        ptr = {memByte({8'h00, z1}), memByte({8'h00, l})};
        s = {1'b0, ptr[7:0]} + {1'b0, y};
        return {1'b1, s[8], 2'd2, 16'(ptr + {8'h00, y})};
      end
      4'd8: begin
        z1 = 8'(l + 8'd1);
        return {1'b1, 1'b0, 2'd3, memByte({h, z1}), memByte({h, l})};
      end
      default: return {1'b0, 1'b0, 2'd1, 16'h0000};
    endcase
  endfunction

  // read responder with programmable wait, logs granted addresses
  initial begin
    forever begin
      @(negedge clk);
      if (memReq) begin
        if (cnt > 0 && memAddr != prevAddr) addrMoved = 1;
        prevAddr = memAddr;
        if (cnt >= waitCycles) begin
          memValid = 1'b1;
          memData  = memByte(memAddr);
          if (reqN < 2) reqLog[reqN] = memAddr;
          reqN++;
          cnt = 0;
        end else begin
          memValid = 1'b0;
          cnt++;
        end
      end else begin
        memValid = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] m, input logic [15:0] p, input logic [7:0] l,
      input logic [7:0] h, input logic [7:0] x, input logic [7:0] y,
      input int w, input bit poke);
    waitCycles = w; reqN = 0; addrMoved = 0;
    reqLog[0] = '0; reqLog[1] = '0;
    @(negedge clk);
    mode = m; pc = p; opLo = l; opHi = h; idxX = x; idxY = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R11: second start while busy
      mode = 4'd4; pc = 16'hDEAD; opLo = 8'h11; opHi = 8'h22; idxY = 8'h99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk("R10 done seen", 32'(seen), 32'd1);
    gotEa = effAddr; gotHas = hasAddr; gotCross = pageCross; gotLen = instLen;
    @(negedge clk);
    doneAgain = done;
  endtask

  initial begin
    logic [19:0] e;
    logic [55:0] v;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 memReq in reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 memReq after reset", 32'(memReq), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      doOp(v[55:52], v[47:32], v[31:24], v[23:16], v[15:8], v[7:0], int'(v[51:48]), 0);
      e = model(v[55:52], v[47:32], v[31:24], v[23:16], v[15:8], v[7:0]);
      chk("R3/R4/R5/R6/R7 effAddr", 32'(gotEa), 32'(e[15:0]));
      chk("R2 instLen", 32'(gotLen), 32'(e[17:16]));
      chk("R6 pageCross", 32'(gotCross), 32'(e[18]));
      chk("R8 hasAddr", 32'(gotHas), 32'(e[19]));
      chk("R10 done one cycle", 32'(doneAgain), 32'd0);
      chk("R8/R9 request count", 32'(reqN),
          (v[55:52] inside {4'd6, 4'd7, 4'd8}) ? 32'd2 : 32'd0);
      chk("R9 address stable while waiting", 32'(addrMoved), 32'd0);
    end

    // R3 latency: non-pointer mode done in cycle after start
    @(negedge clk);
    mode = 4'd3; opLo = 8'h9A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 one-cycle latency", 32'(done), 32'd1);
    chk("R3 zero page value", 32'(effAddr), 32'h009A);

    // R4 relative wrap past top of memory
    doOp(4'd5, 16'hFFFE, 8'h05, 8'h00, 8'h00, 8'h00, 0, 0);
    chk("R4 wrap forward", 32'(gotEa), 32'h0005);
    doOp(4'd5, 16'h0005, 8'h80, 8'h00, 8'h00, 8'h00, 0, 0);
    chk("R4 wrap backward", 32'(gotEa), 32'hFF87);

    // R5 index wraps inside page 0
    doOp(4'd6, 16'h0000, 8'hFE, 8'h77, 8'h03, 8'h00, 0, 0);
    chk("R5 low pointer addr", 32'(reqLog[0]), 32'h0001);
    chk("R5 high pointer addr", 32'(reqLog[1]), 32'h0002);
    doOp(4'd6, 16'h0000, 8'hF0, 8'h77, 8'h0F, 8'h00, 0, 0);
    chk("R5 high addr wraps in page 0", 32'(reqLog[1]), 32'h0000);

    // R6 pointer at 0xFF, high byte from 0x0000
    doOp(4'd7, 16'h0000, 8'hFF, 8'h77, 8'h00, 8'h01, 0, 0);
    chk("R6 low pointer addr", 32'(reqLog[0]), 32'h00FF);
    chk("R6 high pointer addr", 32'(reqLog[1]), 32'h0000);

    // R7 jump pointer at xxFF stays in page
    doOp(4'd8, 16'h0000, 8'hFF, 8'h12, 8'h00, 8'h00, 3, 0);
    chk("R7 low pointer addr", 32'(reqLog[0]), 32'h12FF);
    chk("R7 high pointer addr same page", 32'(reqLog[1]), 32'h1200);
    chk("R9 stable during wait", 32'(addrMoved), 32'd0);

    // R11 start while pointer fetch pending
    doOp(4'd8, 16'h0000, 8'h30, 8'h12, 8'h00, 8'h00, 3, 1);
    e = model(4'd8, 16'h0000, 8'h30, 8'h12, 8'h00, 8'h00);
    chk("R11 busy start ignored (effAddr)", 32'(gotEa), 32'(e[15:0]));
    chk("R11 busy start ignored (len)", 32'(gotLen), 32'd3);
    chk("R11 request log", 32'(reqLog[1]), 32'h1231);
    chk("R11 no extra operation", 32'(doneAgain), 32'd0);

    // R10 results held after done
    repeat (4) @(negedge clk);
    chk("R10 effAddr held", 32'(effAddr), 32'(e[15:0]));
    chk("R10 instLen held", 32'(instLen), 32'd3);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChk++; nErr++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("Result: errors=%0d of %0d checks", nErr, nChk);
        $finish;
      end
    end
  end
endmodule